// File: doc/BRIEF.md
# Programmable AND-OR Logic Plane

The block is the configurable sum-of-products core of a small programmable logic device. Twenty-two logic signals enter the plane: twelve dedicated inputs and ten feedback lines from the output stage. Each signal is offered to the plane both as itself and inverted, which gives 44 columns. Every product term holds a 44-bit selection mask. The term is the AND of the columns its mask selects.

The ten output sums are fixed ORs over groups of terms of unequal size. The groups are largest at the centre outputs and smallest at the two ends. Each output also owns one product term that drives its output enable. Two more terms are shared by all outputs: one drives a global asynchronous reset and one drives a global synchronous preset. Because these are separate terms, no sum term is spent on initialisation.

Masks are loaded one term per clock through a simple write port. From the inputs to the sums, enables and global terms the path is purely combinational. The mask registers are the only state in the block. The output macrocells are not part of this block.

Top module: `pal_array`

## Requirements
- R1: Column 2*i carries signal i and column 2*i+1 carries its complement, for i in 0..21. Signals 0..11 are `ded_i[11:0]` and signals 12..21 are `fb_i[9:0]`. Mask bit c selects column c.
- R2: A product term is the AND of all columns its mask selects. A term whose mask is all zero evaluates to 1.
- R3: A term whose mask selects both column 2*i and column 2*i+1 of the same signal evaluates to 0 for every input value.
- R4: When `cfg_we_i` is high at a rising clock edge, `cfg_mask_i` replaces the mask of term `cfg_idx_i` from that edge on. Writes to indices 132..255 change nothing, and a write to one index leaves every other term unchanged.
- R5: While `rst_ni` is low, and after it is released until a write occurs, every mask is all ones. All sums, enables and global terms are then 0.
- R6: Terms are laid out in blocks in output order. The block of output k starts at index B(k), where B(0)=0 and B(k+1)=B(k)+N(k)+1. Index B(k) is the enable term of output k. Indices B(k)+1 to B(k)+N(k) are its sum terms.
- R7: The number of sum terms N(k) for outputs 0..9 is 8, 10, 12, 14, 16, 16, 14, 12, 10, 8.
- R8: `sum_o[k]` is the OR of the N(k) sum terms of output k. A term programmed to 0 as in R3 has no effect on that OR.
- R9: `oe_o[k]` equals the enable term of output k.
- R10: Term 130 drives `ar_o` (global asynchronous reset) and term 131 drives `sp_o` (global synchronous preset).
- R11: Sums, enables and global terms follow changes on `ded_i` and `fb_i` within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration writes |
| rst_ni | input | 1 | Active-low asynchronous reset; sets every mask to all ones |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_idx_i | input | 8 | Index of the term to write |
| cfg_mask_i | input | 44 | Column selection mask for that term |
| ded_i | input | 12 | Dedicated input signals (signals 0..11) |
| fb_i | input | 10 | Feedback signals (signals 12..21) |
| sum_o | output | 10 | OR of each output's sum terms |
| oe_o | output | 10 | Per-output enable terms |
| ar_o | output | 1 | Global asynchronous reset term |
| sp_o | output | 1 | Global synchronous preset term |

## Verification
The hardest thing to show from the ports is that each of the 132 terms reaches exactly one destination. The uneven group sizes make an off-by-one at a block boundary easy to hide behind an OR. To expose it, the stimulus keeps every term contradictory and sets one term at a time to an empty mask. For each step it records which single output went high, and it tallies those hits per output against the group sizes. Column polarity gets a sweep of its own: a lone column is placed in a single enable term and driven by walking and random input patterns.

// File: rtl/pal_array_pkg.sv
`timescale 1ns/1ps
package pal_array_pkg;
  localparam int unsigned N_DED     = 12;
  localparam int unsigned N_FB      = 10;
  localparam int unsigned N_OUT     = N_FB;
  localparam int unsigned N_SIG     = N_DED + N_FB;
  localparam int unsigned N_COL     = 2 * N_SIG;
  localparam int unsigned MIN_TERMS = 8;
  localparam int unsigned TERM_STEP = 2;

  // sum terms of output k: grows toward the centre, symmetric
  function automatic int unsigned sum_cnt(int unsigned k);
    int unsigned d;
    d = (k < N_OUT - 1 - k) ? k : N_OUT - 1 - k;
    return MIN_TERMS + TERM_STEP * d;
  endfunction

  // first index of output k's block (enable term, then sum terms)
  function automatic int unsigned blk_base(int unsigned k);
    int unsigned b;
    b = 0;
    for (int unsigned j = 0; j < k; j++) b += sum_cnt(j) + 1;
    return b;
  endfunction

  localparam int unsigned N_TERM = blk_base(N_OUT) + 2;
  localparam int unsigned AR_IDX = N_TERM - 2;
  localparam int unsigned SP_IDX = N_TERM - 1;
  localparam int unsigned IDX_W  = $clog2(N_TERM);
endpackage

// File: rtl/pal_fuse_bank.sv
`timescale 1ns/1ps
module pal_fuse_bank #(
  parameter int unsigned N_TERM = 132,
  parameter int unsigned N_COL  = 44,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [N_COL-1:0]              mask_i,
  output logic [N_TERM-1:0][N_COL-1:0]  mask_o
);
  // one register per term; indices past the last term hit no decoder
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(t);
    logic [N_COL-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      mask_q <= '1;
      else if (we_i && idx_i == MY_IDX) mask_q <= mask_i;
    end
    assign mask_o[t] = mask_q;
  end
endmodule

// File: rtl/pal_pterm.sv
`timescale 1ns/1ps
module pal_pterm #(
  parameter int unsigned N_COL = 44
) (
  input  logic [N_COL-1:0] mask_i,
  input  logic [N_COL-1:0] col_i,
  output logic             term_o
);
  // unselected columns read as 1
  assign term_o = &(~mask_i | col_i);
endmodule

// File: rtl/pal_or_group.sv
`timescale 1ns/1ps
module pal_or_group #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] term_i,
  output logic         sum_o
);
  assign sum_o = |term_i;
endmodule

// File: rtl/pal_array.sv
`timescale 1ns/1ps
module pal_array
  import pal_array_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [N_COL-1:0]     cfg_mask_i,
  input  logic [N_DED-1:0]     ded_i,
  input  logic [N_FB-1:0]      fb_i,
  output logic [N_OUT-1:0]     sum_o,
  output logic [N_OUT-1:0]     oe_o,
  output logic                 ar_o,
  output logic                 sp_o
);
  logic [N_SIG-1:0]             sig;
  logic [N_COL-1:0]             col;
  logic [N_TERM-1:0][N_COL-1:0] mask;
  logic [N_TERM-1:0]            pt;

  assign sig = {fb_i, ded_i};

  for (genvar i = 0; i < N_SIG; i++) begin : g_col
    assign col[2*i]   = sig[i];
    assign col[2*i+1] = ~sig[i];
  end

  pal_fuse_bank #(
    .N_TERM (N_TERM),
    .N_COL  (N_COL),
    .IDX_W  (IDX_W)
  ) u_fuse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .mask_i (cfg_mask_i),
    .mask_o (mask)
  );

  for (genvar t = 0; t < N_TERM; t++) begin : g_pt
    pal_pterm #(.N_COL(N_COL)) u_pt (
      .mask_i (mask[t]),
      .col_i  (col),
      .term_o (pt[t])
    );
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int unsigned B = blk_base(k);
    localparam int unsigned C = sum_cnt(k);
    assign oe_o[k] = pt[B];
    pal_or_group #(.W(C)) u_or (
      .term_i (pt[B+1 +: C]),
      .sum_o  (sum_o[k])
    );
  end

  assign ar_o = pt[AR_IDX];
  assign sp_o = pt[SP_IDX];
endmodule

// File: rtl/pal_array_chk.sv
`timescale 1ns/1ps
module pal_array_chk
  import pal_array_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic [IDX_W-1:0]     cfg_idx_i,
  input logic [N_COL-1:0]     cfg_mask_i,
  input logic [N_DED-1:0]     ded_i,
  input logic [N_FB-1:0]      fb_i,
  input logic [N_OUT-1:0]     sum_o,
  input logic [N_OUT-1:0]     oe_o,
  input logic                 ar_o,
  input logic                 sp_o
);
  localparam logic [IDX_W-1:0] AR_I = IDX_W'(AR_IDX);
  localparam logic [IDX_W-1:0] SP_I = IDX_W'(SP_IDX);

  p_blank_after_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (sum_o == '0 && oe_o == '0 && !ar_o && !sp_o));

  p_empty_mask_true_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_idx_i == SP_I && cfg_mask_i == '0) |=> sp_o);

  p_contra_false_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_idx_i == AR_I && cfg_mask_i[1:0] == 2'b11) |=> !ar_o);

  p_other_write_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_idx_i != SP_I) |=>
      (!$stable(ded_i) || !$stable(fb_i) || $stable(sp_o)));

  p_oe0_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_idx_i == '0 && cfg_mask_i == '0) |=> oe_o[0]);
endmodule

bind pal_array pal_array_chk u_chk (.*);

// File: tb/pal_array_tb.sv
`timescale 1ns/1ps
module pal_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  idx = '0;
  logic [43:0] mask = '0;
  logic [11:0] ded = '0;
  logic [9:0]  fb = '0;
  logic [9:0]  sum_o, oe_o;
  logic        ar_o, sp_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [43:0] shadow [132];
  int cnt [10];
  int base [10];
  int hits [10];

  always #2.5 clk = ~clk;

  pal_array dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_mask_i(mask), .ded_i(ded), .fb_i(fb),
    .sum_o(sum_o), .oe_o(oe_o), .ar_o(ar_o), .sp_o(sp_o)
  );

  function automatic logic col_val(int c);
    logic [21:0] s;
    s = {fb, ded};
    return (c % 2 == 1) ? ~s[c/2] : s[c/2];
  endfunction

  function automatic logic term_val(int t);
    logic r;
    r = 1'b1;
    for (int c = 0; c < 44; c++)
      if (shadow[t][c] && !col_val(c)) r = 1'b0;
    return r;
  endfunction

  task automatic check(string req);
    logic [9:0] es, eo;
    logic ea, ep;
    es = '0;
    eo = '0;
    for (int k = 0; k < 10; k++) begin
      eo[k] = term_val(base[k]);
      for (int j = 1; j <= cnt[k]; j++) es[k] = es[k] | term_val(base[k] + j);
    end
    ea = term_val(130);
    ep = term_val(131);
    tests++;
    if (sum_o !== es || oe_o !== eo || ar_o !== ea || sp_o !== ep) begin
      fails++;
      $display("FAIL %s: got sum=%h oe=%h ar=%b sp=%b, exp sum=%h oe=%h ar=%b sp=%b",
               req, sum_o, oe_o, ar_o, sp_o, es, eo, ea, ep);
    end
  endtask

  task automatic write_term(int t, logic [43:0] m);
    @(negedge clk);
    we = 1'b1;
    idx = 8'(t);
    mask = m;
    @(negedge clk);
    we = 1'b0;
    if (t < 132) shadow[t] = m;
  endtask

  task automatic set_in(logic [11:0] d, logic [9:0] f);
    ded = d;
    fb = f;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int t = 0; t < 132; t++) shadow[t] = '1;
    #1;
    check("R5 during reset");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [43:0] sparse_mask();
    logic [63:0] r;
    r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
      & {$urandom, $urandom};
    return r[43:0];
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 10; k++) cnt[k] = 8 + 2 * ((k < 9 - k) ? k : 9 - k);
    base[0] = 0;
    for (int k = 1; k < 10; k++) base[k] = base[k-1] + cnt[k-1] + 1;
    for (int t = 0; t < 132; t++) shadow[t] = '1;

    // R5: blank state under reset and after release
    set_in(12'hA5C, 10'h3C3);
    repeat (3) @(negedge clk);
    check("R5 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R5 after release");
    set_in(12'hFFF, 10'h000);
    check("R5 blank, other inputs");

    // R6 R7 R9 R10: one live term at a time, others contradictory
    for (int k = 0; k < 10; k++) hits[k] = 0;
    for (int t = 0; t < 132; t++) begin
      write_term(t, '0);
      set_in(12'($urandom), 10'($urandom));
      check("R6 R9 R10 term layout");
      for (int k = 0; k < 10; k++) hits[k] += int'(sum_o[k]);
      write_term(t, '1);
    end
    begin
      int exp_cnt [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
      for (int k = 0; k < 10; k++) begin
        tests++;
        if (hits[k] != exp_cnt[k]) begin
          fails++;
          $display("FAIL R7 output %0d: got %0d terms, exp %0d", k, hits[k], exp_cnt[k]);
        end
      end
    end

    // R1 R11: single column in output 3's enable term
    for (int c = 0; c < 44; c++) begin
      write_term(base[3], 44'(1) << c);
      for (int p = 0; p < 4; p++) begin
        if (p < 2) begin
          logic [21:0] w;
          w = (p == 0) ? 22'(1) << (c / 2) : ~(22'(1) << (c / 2));
          set_in(w[11:0], w[21:12]);
        end else begin
          set_in(12'($urandom), 10'($urandom));
        end
        check("R1 R11 column polarity");
      end
    end
    write_term(base[3], '1);

    // R3: both polarities of one signal on the reset term
    for (int i = 0; i < 22; i++) begin
      write_term(130, 44'(3) << (2 * i));
      set_in('0, '0);
      check("R3 contradiction zeros");
      set_in('1, '1);
      check("R3 contradiction ones");
    end
    // R2: empty mask on the preset term
    write_term(131, '0);
    set_in(12'h123, 10'h2AA);
    check("R2 empty mask");

    // R8: output 4 with true-polarity single columns, rest contradictory
    for (int j = 0; j < 12; j++) write_term(base[4] + 1 + j, 44'(1) << (2 * j));
    for (int v = 0; v < 64; v++) begin
      set_in(12'($urandom) & 12'($urandom), 10'($urandom));
      check("R8 OR of terms");
    end
    set_in('0, 10'h3FF);
    check("R8 all selected columns low");

    // R2 R8: sparse random masks everywhere
    for (int t = 0; t < 132; t++) write_term(t, sparse_mask());
    for (int v = 0; v < 300; v++) begin
      set_in(12'($urandom), 10'($urandom));
      check("R2 R8 random plane");
    end

    // R4: out-of-range writes change nothing
    write_term(132, '0);
    check("R4 index 132 ignored");
    write_term(255, '0);
    check("R4 index 255 ignored");
    write_term(200, '1);
    check("R4 index 200 ignored");
    // R4: single-index write leaves others
    write_term(131, '0);
    write_term(0, '1);
    for (int v = 0; v < 16; v++) begin
      set_in(12'($urandom), 10'($urandom));
      check("R4 selective write");
    end

    // R5: reset mid-run clears the plane
    do_reset();
    check("R5 after second reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule